// File: doc/BRIEF.md
# Predicated Vector Condition-Field Writer

This unit expands an integer predicate into a run of consecutive 4-bit condition fields. After a one-cycle start pulse it captures a vector length, a base field index, a 4-bit select mask, a 4-bit polarity pattern, a merge flag, an integer source value, a destination predicate value and a zeroing enable. It then steps through the elements, one per clock. Element i takes bit i of the source value (counted from the least significant end) and compares it against every polarity bit. The selected lanes of the result go to field base+i, and the index wraps at the number of fields.

The destination predicate decides what happens to each element. If its bit is set, the unit writes the computed field. If its bit is clear and zeroing is on, the field is written as 0000. If its bit is clear and zeroing is off, nothing is written, but the element still takes its cycle. When merge is on, the lanes left out by the mask keep their old contents, which the unit reads from the register file model through a read index and returned field data. The register file itself lives outside the block. The unit only issues writes.

The controller has three states. ST_IDLE waits for start. It goes to ST_RUN when the length is non-zero and to ST_FINISH when the length is zero. ST_RUN issues one element per clock, stays there while elements remain, and goes to ST_FINISH after the last one. ST_FINISH raises done for one cycle and returns to ST_IDLE.

Top module: `crf_vec_writer`

## Requirements
- R1: After reset `done` and `wr_en` are 0.
- R2: The start pulse is sampled at a rising edge. Element i is presented in the i-th cycle after that edge (counting from 0), with `wr_idx` = `rd_idx` = (base+i) mod NFIELDS.
- R3: With predicate bit i set, bit k of `wr_data` equals mask[k] AND (mode[k] == src_val[i]) for every lane k where mask[k] is 1. With merge 0, lanes where mask[k] is 0 are 0. For example, mask 1111 with mode 0000 gives NOT of the source bit in every lane.
- R4: With merge 1 and predicate bit set, every lane where mask[k] is 0 takes bit k of `old_field`, which is the current content of field `rd_idx`.
- R5: With predicate bit i clear and zeroing enabled, field base+i is written with 0000, whatever the source bit and the merge flag.
- R6: With predicate bit i clear and zeroing disabled, `wr_en` stays 0 for that element's cycle.
- R7: `done` is 1 for exactly one cycle, the cycle after the last element. A length of 0 gives no writes and `done` in the cycle after the start edge.
- R8: A start pulse that arrives while elements are being issued is ignored, and the running operation keeps its captured operands.
- R9: A length greater than XLEN is treated as XLEN.
- R10: Field indices wrap modulo NFIELDS, and a later element in the same run reads the value an earlier element wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle launch pulse |
| vl | input | $clog2(XLEN+1) | Number of elements |
| base_idx | input | $clog2(NFIELDS) | First destination field |
| sel_mask | input | 4 | Lanes driven by the test |
| polarity | input | 4 | Per-lane compare value |
| merge | input | 1 | Keep unselected lanes from old field |
| src_val | input | XLEN | Integer source predicate |
| dst_pred | input | XLEN | Destination predicate |
| zero_en | input | 1 | Zero fields whose predicate bit is clear |
| old_field | input | 4 | Current content of field rd_idx |
| rd_idx | output | $clog2(NFIELDS) | Field being read for merge |
| wr_en | output | 1 | Field write strobe |
| wr_idx | output | $clog2(NFIELDS) | Field being written |
| wr_data | output | 4 | Field write data |
| done | output | 1 | Operation complete pulse |

## Verification
The bench runs the element transform under several kinds of input. An all-ones mask with zero polarity shows whether the source bit is inverted into every lane. Mixed mask and polarity patterns separate the per-lane compare from the lane select. Merge runs over a preset field file expose any lane that fails to keep old contents. Sparse predicates, run once with zeroing and once without, tell a zero write apart from a skipped write. A wrapping base, a zero length, an oversized length that revisits fields within one run, and a start pulse injected mid-run cover the control corners.

// File: rtl/crf_vec_pkg.sv
package crf_vec_pkg;
    localparam int FIELD_W = 4;

    typedef logic [FIELD_W-1:0] field_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FINISH
    } crf_state_e;
endpackage

// File: rtl/crf_vec_lane.sv
module crf_vec_lane
    import crf_vec_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   active,
    input  logic   src_bit,
    input  logic   pred_bit,
    input  logic   zero_en,
    input  logic   merge,
    input  field_t sel_mask,
    input  field_t polarity,
    input  field_t old_field,
    output logic   wr_en,
    output field_t wr_data
);
    field_t tested;
    field_t kept;

    always_comb begin
        tested  = sel_mask & ~(polarity ^ {FIELD_W{src_bit}});
        kept    = merge ? (old_field & ~sel_mask) : '0;
        wr_en   = 1'b0;
        wr_data = '0;
        if (active) begin
            if (pred_bit) begin
                wr_en   = 1'b1;
                wr_data = tested | kept;
            end else if (zero_en) begin
                wr_en   = 1'b1;
                wr_data = '0;
            end
        end
    end

    AST_KEEP_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (active && pred_bit && merge) |-> ((wr_data & ~sel_mask) == (old_field & ~sel_mask))) // R4
        else $error("unselected lane not kept");
    AST_ZERO_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pred_bit) |-> (wr_data == '0)) // R5
        else $error("cleared predicate wrote non-zero");
endmodule

// File: rtl/crf_vec_ctrl.sv
module crf_vec_ctrl
    import crf_vec_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int NFIELDS = 16,
    localparam int VL_W   = $clog2(XLEN + 1),
    localparam int SEL_W  = $clog2(XLEN),
    localparam int IDX_W  = $clog2(NFIELDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VL_W-1:0]  vl,
    input  logic [IDX_W-1:0] base_idx,
    input  field_t           sel_mask,
    input  field_t           polarity,
    input  logic             merge,
    input  logic [XLEN-1:0]  src_val,
    input  logic [XLEN-1:0]  dst_pred,
    input  logic             zero_en,
    output logic             active,
    output logic             done,
    output logic [IDX_W-1:0] cur_idx,
    output logic             src_bit,
    output logic             pred_bit,
    output field_t           mask_q,
    output field_t           pol_q,
    output logic             merge_q,
    output logic             zero_q
);
    crf_state_e       state;
    logic [VL_W-1:0]  vl_q;
    logic [VL_W-1:0]  elem;
    logic [IDX_W-1:0] base_q;
    logic [XLEN-1:0]  src_q;
    logic [XLEN-1:0]  pred_q;
    logic [VL_W-1:0]  vl_sat;

    assign vl_sat = (vl > VL_W'(XLEN)) ? VL_W'(XLEN) : vl;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            vl_q    <= '0;
            elem    <= '0;
            base_q  <= '0;
            src_q   <= '0;
            pred_q  <= '0;
            mask_q  <= '0;
            pol_q   <= '0;
            merge_q <= 1'b0;
            zero_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        vl_q    <= vl_sat;
                        elem    <= '0;
                        base_q  <= base_idx;
                        src_q   <= src_val;
                        pred_q  <= dst_pred;
                        mask_q  <= sel_mask;
                        pol_q   <= polarity;
                        merge_q <= merge;
                        zero_q  <= zero_en;
                        state   <= (vl_sat == '0) ? ST_FINISH : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (elem == vl_q - VL_W'(1)) begin
                        state <= ST_FINISH;
                    end else begin
                        elem <= elem + VL_W'(1);
                    end
                end
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        active   = (state == ST_RUN);
        done     = (state == ST_FINISH);
        cur_idx  = base_q + IDX_W'(elem);
        src_bit  = src_q[elem[SEL_W-1:0]];
        pred_bit = pred_q[elem[SEL_W-1:0]];
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) // R7
        else $error("done longer than one cycle");
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> (cur_idx == $past(cur_idx) + IDX_W'(1))) // R10
        else $error("field index did not step");
    AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> ($stable(vl_q) && $stable(mask_q) && $stable(src_q))) // R8
        else $error("operands changed while running");
endmodule

// File: rtl/crf_vec_writer.sv
module crf_vec_writer
    import crf_vec_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int NFIELDS = 16,
    localparam int VL_W   = $clog2(XLEN + 1),
    localparam int IDX_W  = $clog2(NFIELDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [VL_W-1:0]      vl,
    input  logic [IDX_W-1:0]     base_idx,
    input  logic [FIELD_W-1:0]   sel_mask,
    input  logic [FIELD_W-1:0]   polarity,
    input  logic                 merge,
    input  logic [XLEN-1:0]      src_val,
    input  logic [XLEN-1:0]      dst_pred,
    input  logic                 zero_en,
    input  logic [FIELD_W-1:0]   old_field,
    output logic [IDX_W-1:0]     rd_idx,
    output logic                 wr_en,
    output logic [IDX_W-1:0]     wr_idx,
    output logic [FIELD_W-1:0]   wr_data,
    output logic                 done
);
    logic             active;
    logic [IDX_W-1:0] cur_idx;
    logic             src_bit;
    logic             pred_bit;
    field_t           mask_q;
    field_t           pol_q;
    logic             merge_q;
    logic             zero_q;

    crf_vec_ctrl #(.XLEN(XLEN), .NFIELDS(NFIELDS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .vl       (vl),
        .base_idx (base_idx),
        .sel_mask (sel_mask),
        .polarity (polarity),
        .merge    (merge),
        .src_val  (src_val),
        .dst_pred (dst_pred),
        .zero_en  (zero_en),
        .active   (active),
        .done     (done),
        .cur_idx  (cur_idx),
        .src_bit  (src_bit),
        .pred_bit (pred_bit),
        .mask_q   (mask_q),
        .pol_q    (pol_q),
        .merge_q  (merge_q),
        .zero_q   (zero_q)
    );

    crf_vec_lane u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .src_bit   (src_bit),
        .pred_bit  (pred_bit),
        .zero_en   (zero_q),
        .merge     (merge_q),
        .sel_mask  (mask_q),
        .polarity  (pol_q),
        .old_field (old_field),
        .wr_en     (wr_en),
        .wr_data   (wr_data)
    );

    assign rd_idx = cur_idx;
    assign wr_idx = cur_idx;

    AST_WRITE_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !done) // R7
        else $error("write during done");
endmodule

// File: tb/sim_crf_vec_writer.sv
module sim_crf_vec_writer;
    localparam int XLEN = 64;
    localparam int NF   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  vl = '0;
    logic [3:0]  base_idx = '0;
    logic [3:0]  sel_mask = '0;
    logic [3:0]  polarity = '0;
    logic        merge = 1'b0;
    logic [63:0] src_val = '0;
    logic [63:0] dst_pred = '0;
    logic        zero_en = 1'b0;
    logic [3:0]  old_field;
    logic [3:0]  rd_idx;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [3:0]  wr_data;
    logic        done;

    logic [3:0]  rf [NF];
    logic [3:0]  xrf [NF];
    int          n_chk = 0;
    int          n_bad = 0;

    always #5ns clk = ~clk;

    crf_vec_writer #(.XLEN(XLEN), .NFIELDS(NF)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .base_idx(base_idx),
        .sel_mask(sel_mask), .polarity(polarity), .merge(merge),
        .src_val(src_val), .dst_pred(dst_pred), .zero_en(zero_en),
        .old_field(old_field), .rd_idx(rd_idx), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .done(done)
    );

    assign old_field = rf[rd_idx];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NF; i++) rf[i] <= 4'(i * 5 + 3);
        end else if (wr_en) begin
            rf[wr_idx] <= wr_data;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] model_field(input logic [3:0] msk, input logic [3:0] pol,
                                               input logic m, input logic s, input logic [3:0] old);
        logic [3:0] r;
        for (int b = 0; b < 4; b++) begin
            if (msk[b]) r[b] = (pol[b] == s);
            else        r[b] = m ? old[b] : 1'b0;
        end
        return r;
    endfunction

    task automatic run_op(input int n, input int base, input logic [3:0] msk, input logic [3:0] pol,
                          input logic m, input logic [63:0] src, input logic [63:0] pred,
                          input logic z, input int poke);
        int nv;
        nv = (n > XLEN) ? XLEN : n;
        for (int i = 0; i < NF; i++) xrf[i] = rf[i];
        @(negedge clk);
        vl = 7'(n); base_idx = 4'(base); sel_mask = msk; polarity = pol;
        merge = m; src_val = src; dst_pred = pred; zero_en = z; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int e = 0; e < nv; e++) begin
            int idx;
            logic xen;
            logic [3:0] xd;
            idx = (base + e) % NF;
            if (pred[e]) begin
                xen = 1'b1; xd = model_field(msk, pol, m, src[e], xrf[idx]);
            end else if (z) begin
                xen = 1'b1; xd = 4'b0000;
            end else begin
                xen = 1'b0; xd = 4'b0000;
            end
            chk(wr_en == xen, pred[e] ? "R3" : (z ? "R5" : "R6"), wr_en, xen);
            chk(done == 1'b0, "R7", done, 0);
            if (xen) begin
                chk(wr_idx == 4'(idx) && rd_idx == 4'(idx), "R2 R10", wr_idx, idx);
                chk(wr_data == xd, m ? "R4" : "R3", wr_data, xd);
                xrf[idx] = xd;
            end
            if (e == poke) begin
                start = 1'b1; sel_mask = ~msk; src_val = ~src; vl = 7'd1;
            end
            @(negedge clk);
            start = 1'b0;
        end
        chk(done == 1'b1, "R7", done, 1);
        chk(wr_en == 1'b0, "R7", wr_en, 0);
        @(negedge clk);
        chk(done == 1'b0, "R7", done, 0);
        chk(wr_en == 1'b0, "R8", wr_en, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1", done, 0);
        chk(wr_en == 1'b0, "R1", wr_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && wr_en == 1'b0, "R1", {done, wr_en}, 0);
        // R3: full mask, zero polarity, merge off
        run_op(8, 3, 4'b1111, 4'b0000, 1'b0, 64'hA5, {64{1'b1}}, 1'b0, -1);
        // R3: mixed mask and polarity
        run_op(12, 0, 4'b0110, 4'b1010, 1'b0, 64'h3C9, {64{1'b1}}, 1'b1, -1);
        // R4: merge keeps unselected lanes
        run_op(10, 5, 4'b0011, 4'b0101, 1'b1, 64'h2D6, {64{1'b1}}, 1'b0, -1);
        // R5: sparse predicate with zeroing and merge
        run_op(9, 2, 4'b1001, 4'b0001, 1'b1, 64'h1F0, 64'h0B5, 1'b1, -1);
        // R6: sparse predicate without zeroing
        run_op(9, 7, 4'b1111, 4'b1100, 1'b0, 64'h0F3, 64'h14A, 1'b0, -1);
        // R10: wrap past the last field
        run_op(5, 14, 4'b0111, 4'b0010, 1'b0, 64'h15, {64{1'b1}}, 1'b0, -1);
        // R7: zero length
        run_op(0, 4, 4'b1111, 4'b0000, 1'b0, 64'h0, {64{1'b1}}, 1'b1, -1);
        // R9: oversized length, repeated fields with merge
        run_op(100, 9, 4'b0101, 4'b0110, 1'b1, 64'hDEAD_BEEF_1234_5678,
               64'hF0F0_FFFF_0F0F_A5A5, 1'b1, -1);
        // R8: start pulse while running is ignored
        run_op(7, 1, 4'b1110, 4'b0100, 1'b0, 64'h55, {64{1'b1}}, 1'b0, 2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2ms;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule